// File: doc/BRIEF.md
# Quality-Ranked Reference Clock Selector

This block picks one timing reference out of several candidates and reports which one it picked. The candidates are external timing inputs and clocks recovered from line ports, plus a free-running local oscillator. The oscillator always has the highest index and has no inputs of its own. Each candidate carries a valid flag, an 8-bit status byte and a configured priority. The low nibble of the status byte is the quality code. In extended mode the high nibble is the identifier of the clock source upstream.

A control unit raises `eval` for one cycle whenever it wants a new decision. On that edge the block ranks the candidates under the chosen mode and applies any manual or forced override. It then registers the result, the quality level and identifier to advertise downstream, and a per-port mask. The mask tells the selected recovered line port to send "do not use" back towards its peer, which prevents a timing loop. When the choice changes, a one-cycle pulse tells the downstream PLL control that a switch took place.

Top module: `ssm_clock_selector`

## Requirements
- R1: While `rst` is high and after it is released, before the first `eval`: `sel_idx` = oscillator index (N_SRC-1), `sel_on_osc` = 1, `adv_ql` = 4'b1011, `adv_id` = 0, `adv_dnu_mask` = 0 and `switch_pulse` = 0.
- R2: The quality codes rank as 4'b0010 (best), 4'b0100, 4'b1000, 4'b1011 (worst usable). Every other code is never chosen on quality in modes 1, 2 and 3: 4'b1111, 4'b0000 and all the reserved values.
- R3: When `mode` = 0 (priority only), every valid candidate is usable and quality is ignored. The smallest `cand_prio` value wins, and equal priorities go to the lowest index.
- R4: When `mode` = 1 or 3 (quality), the best-ranked usable candidate wins. Equal quality is decided by the smaller priority value, then by the lowest index.
- R5: When `mode` = 2 (extended), status bits [3:0] are the quality and bits [7:4] are a source identifier. A candidate whose identifier equals `local_id` is unusable. Otherwise selection follows R4.
- R6: If no candidate is usable, the oscillator (index N_SRC-1) is selected and `sel_on_osc` is 1.
- R7: `ovr_kind` = 1 (manual) selects `ovr_src` if that source is usable under the current mode; the oscillator always counts as usable. Priority is ignored. If the source is unusable, the normal selection applies.
- R8: `ovr_kind` = 2 (forced) selects `ovr_src` whatever its validity, priority or quality. `ovr_kind` = 0 or 3 means no override.
- R9: Outputs change only on the rising edge where `eval` = 1 and are visible from that edge. Without `eval` they hold.
- R10: `switch_pulse` is 1 for exactly the one cycle after an `eval` edge whose result differs from the previous `sel_idx`. Otherwise it is 0.
- R11: `adv_ql` is the selected candidate's status bits [3:0], or 4'b1011 for the oscillator. `adv_id` is the selected candidate's bits [7:4] in mode 2, or `local_id` for the oscillator in mode 2, and 0 in other modes.
- R12: `adv_dnu_mask` has bit i set only when candidate i is selected and is a recovered line port per `LINE_MASK` (default: candidates 1 and 2 are line ports, candidate 0 is external). Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval | input | 1 | Evaluate strobe; one decision per high cycle |
| mode | input | 2 | 0 priority, 1 quality, 2 extended, 3 quality |
| local_id | input | 4 | This node's source identifier |
| cand_valid | input | N_SRC-1 | Per-candidate valid flag |
| cand_s1 | input | 8*(N_SRC-1) | Per-candidate status byte, candidate i at [8i+7:8i] |
| cand_prio | input | PRIO_W*(N_SRC-1) | Per-candidate priority, smaller is better |
| ovr_kind | input | 2 | 0 none, 1 manual, 2 forced, 3 none |
| ovr_src | input | IDX_W | Source index requested by the override |
| sel_idx | output | IDX_W | Selected source index |
| sel_on_osc | output | 1 | Selection is the local oscillator |
| switch_pulse | output | 1 | One-cycle pulse on a change of selection |
| adv_ql | output | 4 | Quality level to advertise downstream |
| adv_id | output | 4 | Source identifier to advertise downstream |
| adv_dnu_mask | output | N_SRC-1 | Line ports that must advertise "do not use" |

## Verification
Every result is registered on the `eval` edge itself, so all outputs are due one edge after the stimulus. `switch_pulse` lasts only the cycle after that edge and is low again one edge later. The bench drives inputs on falling edges, and a behavioural model updates its expected values on the same rising edge as the design. Outputs are compared on the next falling edge, every cycle. Directed scenarios also check hand-worked values right after each strobe, and again after idle cycles to confirm that the outputs hold.

// File: rtl/ssm_sel_pkg.sv
package ssm_sel_pkg;
  typedef enum logic [1:0] {
    MODE_PRIO = 2'd0,
    MODE_QUAL = 2'd1,
    MODE_EXT  = 2'd2,
    MODE_QALT = 2'd3
  } sel_mode_e;

  typedef enum logic [1:0] {
    OVR_NONE   = 2'd0,
    OVR_MANUAL = 2'd1,
    OVR_FORCED = 2'd2,
    OVR_SPARE  = 2'd3
  } ovr_kind_e;

  localparam logic [3:0] QL_EQUIP = 4'b1011;

  // bit 2 set: not selectable on quality; bits 1:0 rank, 0 best
  function automatic logic [2:0] ql_rank(input logic [3:0] code);
    case (code)
      4'b0010: ql_rank = 3'd0;
      4'b0100: ql_rank = 3'd1;
      4'b1000: ql_rank = 3'd2;
      4'b1011: ql_rank = 3'd3;
      default: ql_rank = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ssm_src_grade.sv
module ssm_src_grade
  import ssm_sel_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned KEY_W = PRIO_W + 2
) (
  input  logic [1:0]        mode,
  input  logic [3:0]        local_id,
  input  logic              valid,
  input  logic [7:0]        s1,
  input  logic [PRIO_W-1:0] prio,
  output logic              usable,
  output logic [KEY_W-1:0]  key
);
  logic [2:0] rank;
  logic       id_loop;

  always_comb begin
    rank    = ql_rank(s1[3:0]);
    id_loop = (mode == MODE_EXT) && (s1[7:4] == local_id);
    if (mode == MODE_PRIO) begin
      usable = valid;
      key    = {2'b00, prio};
    end else begin
      usable = valid && !rank[2] && !id_loop;
      key    = {rank[1:0], prio};
    end
  end
endmodule

// File: rtl/ssm_best_pick.sv
module ssm_best_pick #(
  parameter int unsigned NC    = 3,
  parameter int unsigned KEY_W = 5,
  parameter int unsigned IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NC-1:0]     usable,
  input  logic [NC*KEY_W-1:0] keys,
  output logic              found,
  output logic [IDX_W-1:0]  best_idx
);
  logic [KEY_W-1:0] best_key;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_key = '1;
    for (int i = 0; i < NC; i++) begin
      if (usable[i] && (!found || keys[i*KEY_W +: KEY_W] < best_key)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_key = keys[i*KEY_W +: KEY_W];
      end
    end
  end

  // R4
  pick_usable_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> usable[best_idx]);
endmodule

// File: rtl/ssm_clock_selector.sv
module ssm_clock_selector
  import ssm_sel_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned PRIO_W = 3,
  parameter logic [N_SRC-2:0] LINE_MASK = {{(N_SRC-2){1'b1}}, 1'b0},
  localparam int unsigned NC    = N_SRC - 1,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned KEY_W = PRIO_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eval,
  input  logic [1:0]           mode,
  input  logic [3:0]           local_id,
  input  logic [NC-1:0]        cand_valid,
  input  logic [NC*8-1:0]      cand_s1,
  input  logic [NC*PRIO_W-1:0] cand_prio,
  input  logic [1:0]           ovr_kind,
  input  logic [IDX_W-1:0]     ovr_src,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 sel_on_osc,
  output logic                 switch_pulse,
  output logic [3:0]           adv_ql,
  output logic [3:0]           adv_id,
  output logic [NC-1:0]        adv_dnu_mask
);
  localparam logic [IDX_W-1:0] OSC_IDX = IDX_W'(NC);

  logic [NC-1:0]       cand_use;
  logic [NC*KEY_W-1:0] cand_key;
  logic                any_found;
  logic [IDX_W-1:0]    best_idx;
  logic [N_SRC-1:0]    use_all;
  logic                ovr_ok;
  logic [IDX_W-1:0]    nxt_idx;
  logic [7:0]          nxt_s1;
  logic [3:0]          nxt_ql;
  logic [3:0]          nxt_id;
  logic [NC-1:0]       nxt_mask;

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_grade
      ssm_src_grade #(.PRIO_W(PRIO_W)) u_grade (
        .mode    (mode),
        .local_id(local_id),
        .valid   (cand_valid[g]),
        .s1      (cand_s1[g*8 +: 8]),
        .prio    (cand_prio[g*PRIO_W +: PRIO_W]),
        .usable  (cand_use[g]),
        .key     (cand_key[g*KEY_W +: KEY_W])
      );
    end
  endgenerate

  ssm_best_pick #(.NC(NC), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .usable  (cand_use),
    .keys    (cand_key),
    .found   (any_found),
    .best_idx(best_idx)
  );

  assign use_all = {1'b1, cand_use};
  assign ovr_ok  = (32'(ovr_src) < N_SRC);

  always_comb begin
    nxt_idx = any_found ? best_idx : OSC_IDX;
    if (ovr_ok) begin
      if (ovr_kind == OVR_FORCED)
        nxt_idx = ovr_src;
      else if (ovr_kind == OVR_MANUAL && use_all[ovr_src])
        nxt_idx = ovr_src;
    end
  end

  always_comb begin
    nxt_s1   = '0;
    nxt_mask = '0;
    for (int i = 0; i < NC; i++) begin
      if (nxt_idx == IDX_W'(i)) begin
        nxt_s1      = cand_s1[i*8 +: 8];
        nxt_mask[i] = LINE_MASK[i];
      end
    end
    if (nxt_idx == OSC_IDX) begin
      nxt_ql = QL_EQUIP;
      nxt_id = (mode == MODE_EXT) ? local_id : 4'h0;
    end else begin
      nxt_ql = nxt_s1[3:0];
      nxt_id = (mode == MODE_EXT) ? nxt_s1[7:4] : 4'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx      <= OSC_IDX;
      sel_on_osc   <= 1'b1;
      switch_pulse <= 1'b0;
      adv_ql       <= QL_EQUIP;
      adv_id       <= 4'h0;
      adv_dnu_mask <= '0;
    end else if (eval) begin
      sel_idx      <= nxt_idx;
      sel_on_osc   <= (nxt_idx == OSC_IDX);
      switch_pulse <= (nxt_idx != sel_idx);
      adv_ql       <= nxt_ql;
      adv_id       <= nxt_id;
      adv_dnu_mask <= nxt_mask;
    end else begin
      switch_pulse <= 1'b0;
    end
  end

  // R9
  hold_no_eval_chk: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(sel_idx));

  // R10
  pulse_change_chk: assert property (@(posedge clk) disable iff (rst)
    switch_pulse |-> (sel_idx != $past(sel_idx)));

  // R8
  forced_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && ovr_kind == OVR_FORCED && ovr_ok) |=> (sel_idx == $past(ovr_src)));

  // R12
  dnu_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adv_dnu_mask));

  // R11
  osc_adv_chk: assert property (@(posedge clk) disable iff (rst)
    sel_on_osc |-> (adv_ql == QL_EQUIP && adv_dnu_mask == '0));
endmodule

// File: tb/ssm_clock_selector_test.sv
module ssm_clock_selector_test;
  localparam int N_SRC = 4;
  localparam int NC = N_SRC - 1;
  localparam int PW = 3;
  localparam int IW = 2;
  localparam logic [NC-1:0] LINE = 3'b110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] local_id = 4'h5;
  logic [NC-1:0] cand_valid = '0;
  logic [NC*8-1:0] cand_s1 = '0;
  logic [NC*PW-1:0] cand_prio = '0;
  logic [1:0] ovr_kind = 2'd0;
  logic [IW-1:0] ovr_src = '0;
  logic [IW-1:0] sel_idx;
  logic sel_on_osc, switch_pulse;
  logic [3:0] adv_ql, adv_id;
  logic [NC-1:0] adv_dnu_mask;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int e_sel = NC;
  int e_pulse = 0;
  int e_ql = 11;
  int e_id = 0;
  int e_mask = 0;

  always #5 clk = ~clk;

  ssm_clock_selector #(.N_SRC(N_SRC), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .eval(eval), .mode(mode), .local_id(local_id),
    .cand_valid(cand_valid), .cand_s1(cand_s1), .cand_prio(cand_prio),
    .ovr_kind(ovr_kind), .ovr_src(ovr_src), .sel_idx(sel_idx),
    .sel_on_osc(sel_on_osc), .switch_pulse(switch_pulse), .adv_ql(adv_ql),
    .adv_id(adv_id), .adv_dnu_mask(adv_dnu_mask)
  );

  function automatic int rank_of(int q);
    case (q)
      2: return 0;
      4: return 1;
      8: return 2;
      11: return 3;
      default: return -1;
    endcase
  endfunction

  // behavioural reference model, updated on the same edge as the design
  always @(posedge clk) begin
    int best, bkey, pick, ql, id, r, key;
    bit ok [NC+1];
    if (rst) begin
      e_sel <= NC; e_pulse <= 0; e_ql <= 11; e_id <= 0; e_mask <= 0;
    end else if (eval) begin
      best = -1; bkey = 0;
      for (int i = 0; i < NC; i++) begin
        ql = int'(cand_s1[i*8 +: 4]);
        id = int'(cand_s1[i*8+4 +: 4]);
        r = rank_of(ql);
        ok[i] = cand_valid[i];
        if (mode != 0) ok[i] = ok[i] && (r >= 0);
        if (mode == 2) ok[i] = ok[i] && (id != int'(local_id));
        key = ((mode == 0) ? 0 : r) * 1000 + int'(cand_prio[i*PW +: PW]);
        if (ok[i] && (best < 0 || key < bkey)) begin best = i; bkey = key; end
      end
      ok[NC] = 1;
      pick = (best < 0) ? NC : best;
      if (ovr_kind == 2) pick = int'(ovr_src);
      else if (ovr_kind == 1 && ok[int'(ovr_src)]) pick = int'(ovr_src);
      e_pulse <= (pick != e_sel);
      e_sel <= pick;
      if (pick == NC) begin
        e_ql <= 11; e_id <= (mode == 2) ? int'(local_id) : 0; e_mask <= 0;
      end else begin
        e_ql <= int'(cand_s1[pick*8 +: 4]);
        e_id <= (mode == 2) ? int'(cand_s1[pick*8+4 +: 4]) : 0;
        e_mask <= LINE[pick] ? (1 << pick) : 0;
      end
    end else begin
      e_pulse <= 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R3/R4/R5/R6/R7/R8 model sel_idx", int'(sel_idx), e_sel);
      check("R6 model sel_on_osc", int'(sel_on_osc), (e_sel == NC) ? 1 : 0);
      check("R10 model switch_pulse", int'(switch_pulse), e_pulse);
      check("R11 model adv_ql", int'(adv_ql), e_ql);
      check("R11 model adv_id", int'(adv_id), e_id);
      check("R12 model adv_dnu_mask", int'(adv_dnu_mask), e_mask);
    end
  end

  task automatic set_src(int i, bit v, int id, int ql, int pr);
    cand_valid[i] = v;
    cand_s1[i*8 +: 8] = {4'(id), 4'(ql)};
    cand_prio[i*PW +: PW] = PW'(pr);
  endtask

  // strobe eval for one edge; returns at the falling edge after it
  task automatic strobe();
    eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset sel_idx", int'(sel_idx), NC);
    check("R1 reset adv_ql", int'(adv_ql), 11);
    check("R1 reset mask", int'(adv_dnu_mask), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release sel_on_osc", int'(sel_on_osc), 1);
    check("R1 after release pulse", int'(switch_pulse), 0);

    // R3: priority mode, quality ignored, tie to lowest index
    mode = 2'd0;
    set_src(0, 1, 0, 15, 5); set_src(1, 1, 0, 15, 2); set_src(2, 1, 0, 15, 2);
    strobe();
    check("R3 prio pick", int'(sel_idx), 1);
    check("R10 pulse on change", int'(switch_pulse), 1);
    check("R12 line mask", int'(adv_dnu_mask), 2);
    @(negedge clk);
    check("R10 pulse one cycle", int'(switch_pulse), 0);

    // R4 / R2: quality ranking
    mode = 2'd1;
    set_src(0, 1, 0, 2, 5); set_src(1, 1, 0, 8, 2); set_src(2, 1, 0, 4, 2);
    strobe();
    check("R4 best quality", int'(sel_idx), 0);
    check("R11 adv_ql", int'(adv_ql), 2);
    check("R12 external no mask", int'(adv_dnu_mask), 0);

    set_src(0, 1, 0, 15, 0); set_src(1, 1, 0, 4, 3); set_src(2, 1, 0, 4, 1);
    strobe();
    check("R4 equal quality by prio", int'(sel_idx), 2);

    // R2 / R6: reserved and DNU codes unusable -> oscillator
    set_src(0, 1, 0, 0, 0); set_src(1, 1, 0, 3, 0); set_src(2, 1, 0, 15, 0);
    strobe();
    check("R2 R6 fallback osc", int'(sel_idx), NC);
    check("R11 osc adv_ql", int'(adv_ql), 11);

    // R5: extended mode with id loop rejection
    mode = 2'd2;
    set_src(0, 1, 5, 2, 0); set_src(1, 1, 7, 4, 0); set_src(2, 1, 0, 8, 0);
    strobe();
    check("R5 id loop rejected", int'(sel_idx), 1);
    check("R11 adv_id", int'(adv_id), 7);

    // R9: no eval, outputs hold
    set_src(1, 0, 0, 15, 7);
    repeat (4) @(negedge clk);
    check("R9 hold without eval", int'(sel_idx), 1);
    check("R9 adv hold", int'(adv_ql), 4);

    // R7: manual override
    mode = 2'd1;
    set_src(0, 1, 0, 2, 0); set_src(1, 1, 0, 4, 7); set_src(2, 1, 0, 15, 0);
    ovr_kind = 2'd1; ovr_src = 2'd1;
    strobe();
    check("R7 manual to usable", int'(sel_idx), 1);
    ovr_src = 2'd2;
    strobe();
    check("R7 manual to unusable -> normal", int'(sel_idx), 0);

    // R8: forced override ignores validity and quality
    set_src(2, 0, 0, 15, 7);
    ovr_kind = 2'd2; ovr_src = 2'd2;
    strobe();
    check("R8 forced pick", int'(sel_idx), 2);
    check("R11 forced adv_ql", int'(adv_ql), 15);
    strobe();
    check("R10 no pulse same pick", int'(switch_pulse), 0);

    // R6: priority mode with no valid candidate
    ovr_kind = 2'd0; mode = 2'd0; cand_valid = '0;
    strobe();
    check("R6 all invalid -> osc", int'(sel_idx), NC);
    check("R6 osc flag", int'(sel_on_osc), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule